// File: doc/BRIEF.md
# Queue Run Control Register

This block is the command register that starts and stops a set of DMA queues through one write port. A single write carries two byte lanes. The low byte is a start mask: each one bit starts the queue it indexes. The next byte is a stop mask: each one bit asks the queue it indexes to stop. A start takes effect on the next clock. A stop is only a request. The queue keeps running until its engine reports that it is idle, and only then does its run bit drop.

Software reads the register to find out which queues are still active. After it sends a stop, it polls until the queue's run bit has cleared. The read word also shows which stops are still waiting for their engine to go idle. Each queue engine gets a run level and a one-cycle kick pulse. The kick is raised by every accepted start, including a start to a queue that is already running, so an engine can treat it as a prompt to fetch descriptors again.

Top module: `qrun_cmd_reg`

## Requirements
- R1: During and after reset, every run bit, every pending-stop bit and every kick pulse is zero, and `rd_data` reads as zero.
- R2: A write with bit q of `wr_data[7:0]` set makes `run_o[q]` high from the next clock. A zero bit in that lane leaves queue q as it was.
- R3: A write with bit q+8 set, to a queue that is running, marks a pending stop. While the stop is pending, `run_o[q]` stays high for as long as `idle_i[q]` is low.
- R4: When a stop is pending and `idle_i[q]` is high at a clock edge, both `run_o[q]` and the pending stop clear at that edge.
- R5: If a write sets both bit q and bit q+8, the stop wins: the start is dropped and no kick is raised.
- R6: A start to a queue that is already running leaves it running, cancels any pending stop on it, and raises `kick_o[q]` for exactly one cycle. Every accepted start raises that same one-cycle kick.
- R7: A stop written to a queue that is not running has no effect.
- R8: `rd_data` has the run bits in [7:0] and the pending-stop bits in [15:8]. Bits [31:16] always read zero, and writing them has no effect.
- R9: `idle_i[q]` has no effect on a queue that has no stop pending.
- R10: Each queue acts only on its own bits, so a write that sets several bits changes each of those queues independently and leaves the others untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 32 | Command word: start mask [7:0], stop mask [15:8] |
| idle_i | input | 8 | Per-queue idle report from the engines |
| run_o | output | 8 | Per-queue run level |
| kick_o | output | 8 | Per-queue one-cycle pulse on an accepted start |
| rd_data | output | 32 | Status word: run bits [7:0], pending stops [15:8] |

## Verification
The bench goes after the following corner cases:

- **Held stop.** It holds a stop request for several cycles with the engine busy, then raises idle. A design that clears the run bit on the write itself would show the queue idle too early, and software would free rings still in use.
- **Same-write conflict.** It writes start and stop to one queue in the same write. A design that lets the start win would keep kicking a queue that software is trying to stop.
- **Restart kick.** It restarts a queue that has a stop pending. It expects one kick and the stop cancelled, which catches both a missing kick and a stale stop that would later drop a queue that was restarted.
- **Ignored inputs.** It raises idle with no stop pending, sends stops to queues that are not running, and writes the upper half-word. A design that acts on any of these would corrupt the run bits or show a nonzero upper read.

// File: rtl/qrun_pkg.sv
package qrun_pkg;
  localparam int unsigned NQ     = 8;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned START_LO = 0;
  localparam int unsigned STOP_LO  = LANE_W;

  typedef struct packed {
    logic [NQ-1:0] start;
    logic [NQ-1:0] stop;
  } qrun_cmd_t;
endpackage

// File: rtl/qrun_decode.sv
module qrun_decode
  import qrun_pkg::*;
#(
  parameter int unsigned N_Q = NQ,
  parameter int unsigned W   = WORD_W
) (
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [N_Q-1:0] run,
  input  logic [N_Q-1:0] pend,
  output logic [N_Q-1:0] start,
  output logic [N_Q-1:0] stop,
  output logic [W-1:0]  rd_data
);
  localparam int unsigned USED_W = 2 * LANE_W;

  // Slice the two byte lanes of the write; everything above them is dropped.
  always_comb begin
    start = '0;
    stop  = '0;
    if (wr_en) begin
      start = wr_data[START_LO +: N_Q];
      stop  = wr_data[STOP_LO  +: N_Q];
    end
  end

  // Pack the status word: run bits low, pending stops in the next lane.
  always_comb begin
    rd_data = '0;
    rd_data[START_LO +: N_Q] = run;
    rd_data[STOP_LO  +: N_Q] = pend;
  end

  // R8
  upper_zero_chk: assert final (rd_data[W-1:USED_W] == '0);
endmodule

// File: rtl/qrun_lane.sv
module qrun_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic idle_i,
  output logic run_o,
  output logic pend_o,
  output logic kick_o
);
  logic run_q, pend_q, kick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= start_i && !stop_i;
      if (stop_i) begin
        if (run_q) pend_q <= 1'b1;
      end else if (start_i) begin
        run_q  <= 1'b1;
        pend_q <= 1'b0;
      end else if (pend_q && idle_i) begin
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  assign run_o  = run_q;
  assign pend_o = pend_q;
  assign kick_o = kick_q;

  // R2
  start_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (run_q && kick_q && !pend_q));
  // R3
  stop_holds_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (stop_i || (pend_q && !idle_i))) |=> run_q);
  // R4
  idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && idle_i && !start_i && !stop_i) |=> (!run_q && !pend_q));
  // R5
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && stop_i) |=> !kick_q);
  // R7
  pend_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> run_q);
  // R9
  idle_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !pend_q && !stop_i) |=> run_q);
endmodule

// File: rtl/qrun_cmd_reg.sv
module qrun_cmd_reg
  import qrun_pkg::*;
#(
  parameter int unsigned N_Q = NQ,
  parameter int unsigned W   = WORD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  input  logic [N_Q-1:0] idle_i,
  output logic [N_Q-1:0] run_o,
  output logic [N_Q-1:0] kick_o,
  output logic [W-1:0]   rd_data
);
  qrun_cmd_t     cmd;
  logic [N_Q-1:0] pend;

  qrun_decode #(.N_Q(N_Q), .W(W)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .run     (run_o),
    .pend    (pend),
    .start   (cmd.start),
    .stop    (cmd.stop),
    .rd_data (rd_data)
  );

  for (genvar q = 0; q < N_Q; q++) begin : g_lane
    qrun_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (cmd.start[q]),
      .stop_i  (cmd.stop[q]),
      .idle_i  (idle_i[q]),
      .run_o   (run_o[q]),
      .pend_o  (pend[q]),
      .kick_o  (kick_o[q])
    );
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (run_o == '0 && kick_o == '0 && pend == '0));
  // R6
  kick_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_o != '0 && cmd.start == '0) |=> (kick_o == '0));
endmodule

// File: tb/test_qrun_cmd_reg.sv
module test_qrun_cmd_reg;
  localparam int NQ = 8;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [NQ-1:0] idle_i = '0;
  logic [NQ-1:0] run_o, kick_o;
  logic [W-1:0]  rd_data;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [W-1:0]  rd;
    logic [NQ-1:0] kick;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic [NQ-1:0] m_run = '0, m_pend = '0;

  always #10 clk = ~clk;

  qrun_cmd_reg i_qrun_cmd_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .idle_i(idle_i), .run_o(run_o), .kick_o(kick_o), .rd_data(rd_data)
  );

  // Driver: applies one cycle of stimulus at the falling edge and pushes the
  // state expected after the next rising edge.
  task automatic step(input logic we, input logic [W-1:0] wd,
                      input logic [NQ-1:0] idl, input string tag);
    logic [NQ-1:0] st, sp, k;
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = wd; idle_i = idl;
    st = we ? wd[7:0]  : '0;
    sp = we ? wd[15:8] : '0;
    k = '0;
    for (int q = 0; q < NQ; q++) begin
      if (sp[q]) begin
        if (m_run[q]) m_pend[q] = 1'b1;
      end else if (st[q]) begin
        m_run[q] = 1'b1; m_pend[q] = 1'b0; k[q] = 1'b1;
      end else if (m_pend[q] && idl[q]) begin
        m_run[q] = 1'b0; m_pend[q] = 1'b0;
      end
    end
    e.rd = {16'h0, m_pend, m_run};
    e.kick = k;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk); #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (rd_data !== e.rd || kick_o !== e.kick || run_o !== e.rd[7:0]) begin
          fails++;
          $display("FAIL %s: rd=%h kick=%h run=%h expected rd=%h kick=%h",
                   e.tag, rd_data, kick_o, run_o, e.rd, e.kick);
        end
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (rd_data !== '0 || run_o !== '0 || kick_o !== '0) begin
      fails++;
      $display("FAIL R1: rd=%h run=%h kick=%h expected all zero", rd_data, run_o, kick_o);
    end
    @(negedge clk); rst_n = 1'b1;

    step(1'b1, 32'h0000_0001, 8'h00, "R2 start q0");
    step(1'b0, 32'h0,         8'h00, "R6 kick single cycle");
    step(1'b1, 32'h0000_00A4, 8'h00, "R10 start q2 q5 q7");
    step(1'b1, 32'h0000_0000, 8'h00, "R2 zero lane no effect");
    step(1'b0, 32'h0,         8'hFF, "R9 idle without stop");
    step(1'b0, 32'h0,         8'hFF, "R9 idle without stop hold");
    step(1'b1, 32'h0000_0100, 8'h00, "R3 stop q0 pending");
    step(1'b0, 32'h0,         8'h00, "R3 run held while busy");
    step(1'b0, 32'h0,         8'h00, "R3 run held while busy 2");
    step(1'b0, 32'h0,         8'h01, "R4 idle clears q0");
    step(1'b0, 32'h0,         8'h00, "R4 q0 stays stopped");
    step(1'b1, 32'h0000_0800, 8'h00, "R7 stop on stopped q3");
    step(1'b1, 32'h0000_0404, 8'h00, "R5 stop wins on q2");
    step(1'b0, 32'h0,         8'h00, "R5 no kick");
    step(1'b1, 32'h0000_0004, 8'h00, "R6 restart cancels stop q2");
    step(1'b0, 32'h0,         8'h04, "R6 q2 survives idle");
    step(1'b1, 32'hFFFF_0000, 8'h00, "R8 upper half ignored");
    step(1'b1, 32'h0000_0202, 8'h02, "R5 R7 conflict on stopped q1");
    step(1'b1, 32'h0000_A000, 8'h20, "R10 stop q5 q7 idle q5");
    step(1'b0, 32'h0,         8'h20, "R4 q5 clears q7 waits");
    step(1'b0, 32'h0,         8'h80, "R4 q7 clears");
    step(1'b1, 32'h0000_FF00, 8'hFF, "R3 stop all");
    step(1'b0, 32'h0,         8'hFF, "R4 all clear");
    step(1'b0, 32'h0,         8'h00, "R1 final idle");
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule